// File: doc/BRIEF.md
# Gated Multi-Channel Rate Scaler with Live and Dead Time

The block counts events on a bank of input channels over a window whose length is measured in timebase ticks. The timebase is either the block's own clock (one tick every cycle, a 20 ns tick at 50 MHz) or an external strobe, chosen by a configuration bit. A veto input suspends channel counting. A test input makes every channel count in every cycle, whatever the veto and the hits. Two wide accumulators measure, in ticks, how long the veto was low (live time) and how long it was high (dead time).

When a window closes, every channel count and both time totals are copied into a readout bank in one step. The active counters then start again from zero, so software can read the finished window while the next one accumulates. A clear input restarts the active counters, the time totals and the window position, and leaves the readout bank alone. All counters hold at their all-ones value instead of wrapping.

Top module: `rate_scaler`

## Requirements
- R1: After reset, every readout channel, the live and dead totals and the window-done flag read zero.
- R2: With veto low and test low, a channel gains one count for each clock cycle in which its hit input is high.
- R3: While veto is high and test is low, no channel counts, whatever its hit input.
- R4: While test is high, every channel gains one count per clock cycle, regardless of veto and of its hit input.
- R5: A high clear in a cycle zeroes the active channel counters, the live and dead accumulators and the window position at the next edge. Events in that cycle are dropped, and the readout bank keeps its contents.
- R6: A window spans winLen ticks; a winLen of 0 is taken as 1. At the edge of the last tick, the readout bank takes the totals including that cycle, the active counters restart at zero, and winDone is high for the one following cycle only.
- R7: The live accumulator gains one on each tick with veto low. The dead accumulator gains one on each tick with veto high.
- R8: With tickSelExt low every clock cycle is a tick. With tickSelExt high only cycles with extStrobe high are ticks. Channels count per clock cycle in both cases.
- R9: Channel counters and time accumulators stop at all ones and do not wrap.
- R10: rdCount shows the banked count of channel rdSel; a rdSel at or above NUM_CH reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one internal tick per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Synchronous restart of active counters and window |
| vetoIn | input | 1 | High suspends channel counting and marks dead ticks |
| testIn | input | 1 | High forces all channels to count |
| tickSelExt | input | 1 | 0: internal tick every cycle, 1: tick on extStrobe |
| extStrobe | input | 1 | External tick, one cycle per tick |
| winLen | input | WIN_W | Window length in ticks (0 acts as 1) |
| hits | input | NUM_CH | Per-channel event inputs, one event per high cycle |
| rdSel | input | SEL_W | Channel index for readout |
| rdCount | output | CNT_W | Banked count of the selected channel |
| liveOut | output | TIME_W | Banked live-time total |
| deadOut | output | TIME_W | Banked dead-time total |
| winDone | output | 1 | One-cycle pulse after the bank is refreshed |

## Verification
The assertions take winLen and tickSelExt as held steady for the length of a window. They treat a hit that stays high for several cycles as several events, and extStrobe as already synchronous and one cycle wide per tick. The stimulus changes winLen and the tick source only just after a clear or just after a window has closed, holds each input pattern for whole windows, and pulses the strobe for single cycles. Saturation is reached with a narrow counter width, so the hold at all ones is exercised in a short run.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Strobes that the control half hands to the datapath each cycle
  typedef struct packed {
    logic tick;    // a timebase tick happens this cycle
    logic winEnd;  // this tick is the last of the window
    logic clr;     // restart active counters and window
  } ctrl_s;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearIn,
  input  logic             tickSelExt,
  input  logic             extStrobe,
  input  logic [WIN_W-1:0] winLen,
  output ctrl_s            strobes
);
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] lastIdx;
  logic             tick;

  assign tick    = tickSelExt ? extStrobe : 1'b1;
  assign lastIdx = (winLen == '0) ? '0 : winLen - 1'b1;

  assign strobes.tick   = tick;
  assign strobes.clr    = clearIn;
  assign strobes.winEnd = tick && !clearIn && (winCnt >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                winCnt <= '0;
    else if (clearIn)         winCnt <= '0;
    else if (strobes.winEnd)  winCnt <= '0;
    else if (tick)            winCnt <= winCnt + 1'b1;
  end

  // R8: without a tick the window position does not move
  assert_window_waits_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !clearIn) |=> $stable(winCnt));

  // R5: a clear puts the window back at its first tick
  assert_clear_rewinds_R5: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (winCnt == '0));
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int NUM_CH = 80,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 64,
  parameter int SEL_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             strobes,
  input  logic              vetoIn,
  input  logic              testIn,
  input  logic [NUM_CH-1:0] hits,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [CNT_W-1:0]  rdCount,
  output logic [TIME_W-1:0] liveOut,
  output logic [TIME_W-1:0] deadOut,
  output logic              winDone
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [TIME_W-1:0] TIME_MAX = '1;

  logic [CNT_W-1:0]  cnt  [NUM_CH];
  logic [CNT_W-1:0]  bank [NUM_CH];
  logic [TIME_W-1:0] live, dead, liveNext, deadNext;
  logic              liveInc, deadInc;

  // Per-channel saturating counter with its readout slot
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic             inc;
    logic [CNT_W-1:0] nextCnt;

    assign inc     = testIn || (hits[ch] && !vetoIn);
    assign nextCnt = (inc && cnt[ch] != CNT_MAX) ? cnt[ch] + 1'b1 : cnt[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[ch]  <= '0;
        bank[ch] <= '0;
      end else if (strobes.clr) begin
        cnt[ch]  <= '0;
      end else if (strobes.winEnd) begin
        bank[ch] <= nextCnt;
        cnt[ch]  <= '0;
      end else begin
        cnt[ch]  <= nextCnt;
      end
    end

    assert_veto_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
      (vetoIn && !testIn && !strobes.clr && !strobes.winEnd) |=> $stable(cnt[ch]));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[ch] == CNT_MAX && !strobes.clr && !strobes.winEnd) |=> (cnt[ch] == CNT_MAX));
  end

  // Live and dead time accumulate timebase ticks
  assign liveInc  = strobes.tick && !vetoIn;
  assign deadInc  = strobes.tick && vetoIn;
  assign liveNext = (liveInc && live != TIME_MAX) ? live + 1'b1 : live;
  assign deadNext = (deadInc && dead != TIME_MAX) ? dead + 1'b1 : dead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live    <= '0;
      dead    <= '0;
      liveOut <= '0;
      deadOut <= '0;
      winDone <= 1'b0;
    end else begin
      winDone <= strobes.winEnd;
      if (strobes.clr) begin
        live <= '0;
        dead <= '0;
      end else if (strobes.winEnd) begin
        liveOut <= liveNext;
        deadOut <= deadNext;
        live    <= '0;
        dead    <= '0;
      end else begin
        live <= liveNext;
        dead <= deadNext;
      end
    end
  end

  // Readout mux over the bank; out-of-range index reads zero
  always_comb begin
    rdCount = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdSel == SEL_W'(i)) rdCount = bank[i];
    end
  end

  assert_live_needs_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(strobes.tick && !vetoIn) && !strobes.clr && !strobes.winEnd) |=> $stable(live));

  assert_dead_needs_veto_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(strobes.tick && vetoIn) && !strobes.clr && !strobes.winEnd) |=> $stable(dead));

  assert_bank_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.winEnd |=> ($stable(liveOut) && $stable(deadOut) && !winDone));

  assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (live == '0 && dead == '0));
endmodule

// File: rtl/rate_scaler.sv
module rate_scaler
  import rs_pkg::*;
#(
  parameter int NUM_CH = 80,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 64,
  parameter int WIN_W  = 32,
  localparam int SEL_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearIn,
  input  logic              vetoIn,
  input  logic              testIn,
  input  logic              tickSelExt,
  input  logic              extStrobe,
  input  logic [WIN_W-1:0]  winLen,
  input  logic [NUM_CH-1:0] hits,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [CNT_W-1:0]  rdCount,
  output logic [TIME_W-1:0] liveOut,
  output logic [TIME_W-1:0] deadOut,
  output logic              winDone
);
  ctrl_s strobes;

  rs_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clearIn    (clearIn),
    .tickSelExt (tickSelExt),
    .extStrobe  (extStrobe),
    .winLen     (winLen),
    .strobes    (strobes)
  );

  rs_datapath #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .TIME_W (TIME_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .vetoIn  (vetoIn),
    .testIn  (testIn),
    .hits    (hits),
    .rdSel   (rdSel),
    .rdCount (rdCount),
    .liveOut (liveOut),
    .deadOut (deadOut),
    .winDone (winDone)
  );
endmodule

// File: tb/rate_scaler_bench.sv
module rate_scaler_bench;
  localparam int CLK_PERIOD = 20;
  localparam int NCH   = 4;
  localparam int CW    = 8;
  localparam int TW    = 16;
  localparam int WW    = 16;
  localparam int SW    = $clog2(NCH + 1);
  localparam int WLEN  = 10;
  localparam int NVEC  = 5;

  // {veto, test, hits[3:0], expected counting channels[3:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'b0101, 4'b0101},
    {1'b1, 1'b0, 4'b1111, 4'b0000},
    {1'b1, 1'b1, 4'b0000, 4'b1111},
    {1'b0, 1'b1, 4'b0011, 4'b1111},
    {1'b0, 1'b0, 4'b1010, 4'b1010}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clearIn = 1'b0, vetoIn = 1'b0, testIn = 1'b0;
  logic          tickSelExt = 1'b0, extStrobe = 1'b0;
  logic [WW-1:0] winLen = '0;
  logic [NCH-1:0] hits = '0;
  logic [SW-1:0] rdSel = '0;
  logic [CW-1:0] rdCount;
  logic [TW-1:0] liveOut, deadOut;
  logic          winDone;
  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_scaler #(.NUM_CH(NCH), .CNT_W(CW), .TIME_W(TW), .WIN_W(WW)) u_rate_scaler (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .vetoIn(vetoIn), .testIn(testIn),
    .tickSelExt(tickSelExt), .extStrobe(extStrobe), .winLen(winLen), .hits(hits),
    .rdSel(rdSel), .rdCount(rdCount), .liveOut(liveOut), .deadOut(deadOut),
    .winDone(winDone)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readCh(input int ch, output longint val);
    rdSel = SW'(ch);
    #1;
    val = rdCount;
  endtask

  task automatic doClear();
    clearIn = 1'b1;
    step();
    clearIn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    longint v;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int ch = 0; ch < NCH; ch++) begin
      readCh(ch, v);
      check("R1 bank count", v, 0);
    end
    check("R1 live", liveOut, 0);
    check("R1 dead", deadOut, 0);
    check("R1 winDone", winDone, 0);

    winLen = WW'(WLEN);
    doClear();

    // Vector table: each entry fills one whole window
    for (int k = 0; k < NVEC; k++) begin
      vetoIn = VEC[k][9];
      testIn = VEC[k][8];
      hits   = VEC[k][7:4];
      repeat (WLEN - 1) step();
      check("R6 no done mid-window", winDone, 0);
      step();
      check("R6 done after last tick", winDone, 1);
      for (int ch = 0; ch < NCH; ch++) begin
        readCh(ch, v);
        // R2 counting, R3 veto gating, R4 test forcing
        check(VEC[k][8] ? "R4 test count" : (VEC[k][9] ? "R3 veto count" : "R2 hit count"),
              v, VEC[k][ch] ? WLEN : 0);
      end
      check("R7 live", liveOut, VEC[k][9] ? 0 : WLEN);
      check("R7 dead", deadOut, VEC[k][9] ? WLEN : 0);
    end
    vetoIn = 1'b0;
    testIn = 1'b0;

    // R5: clear restarts the window and keeps the bank
    hits = 4'b0001;
    repeat (3) step();
    doClear();
    readCh(1, v);
    check("R5 bank kept ch1", v, WLEN);
    readCh(0, v);
    check("R5 bank kept ch0", v, 0);
    repeat (WLEN - 1) step();
    check("R5 window restarted", winDone, 0);
    step();
    readCh(0, v);
    check("R5 count after clear", v, WLEN);
    check("R5 live after clear", liveOut, WLEN);

    // R6: zero length acts as one tick
    winLen = '0;
    step();
    readCh(0, v);
    check("R6 len0 count", v, 1);
    check("R6 len0 live", liveOut, 1);
    check("R6 len0 done", winDone, 1);
    hits = '0;
    step();
    readCh(0, v);
    check("R6 len0 empty", v, 0);
    check("R6 len0 done again", winDone, 1);

    // R8: external ticks, window of three strobes
    winLen = WW'(3);
    tickSelExt = 1'b1;
    doClear();
    hits = 4'b0001;
    for (int c = 0; c < 6; c++) begin
      extStrobe = (c == 0 || c == 3 || c == 5);
      step();
      if (c == 4) check("R8 no end before third strobe", winDone, 0);
    end
    extStrobe = 1'b0;
    hits = '0;
    check("R8 done on third strobe", winDone, 1);
    readCh(0, v);
    check("R8 channel counts every cycle", v, 6);
    check("R8 live counts strobes", liveOut, 3);
    check("R8 dead", deadOut, 0);

    // R9: saturation with a narrow counter
    tickSelExt = 1'b0;
    winLen = WW'(300);
    doClear();
    testIn = 1'b1;
    repeat (300) step();
    testIn = 1'b0;
    check("R9 done", winDone, 1);
    readCh(0, v);
    check("R9 ch0 saturated", v, 255);
    readCh(3, v);
    check("R9 ch3 saturated", v, 255);
    check("R9 live not saturated", liveOut, 300);

    // R10: out-of-range index reads zero
    readCh(4, v);
    check("R10 index 4", v, 0);
    readCh(7, v);
    check("R10 index 7", v, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule